// File: doc/BRIEF.md
# Byte-Lane EDO DRAM Access Controller

This block turns single user requests into one random-access cycle on a 1M x 16 EDO DRAM. The DRAM has a 12-pin multiplexed address and two column strobes, one for each byte lane. The user raises `req` with a direction flag, a 20-bit word address, 16-bit write data and a 2-bit byte enable. It keeps `req` high until `rsp_ack` pulses, then lowers it. On a read, `rsp_rdata` holds the returned word during the cycle in which `rsp_ack` is high.

Every access runs the same fixed sequence, with each phase measured in whole clock cycles. First the row address is presented with RAS low. Next the column address is presented, one cycle before the column strobes fall. The strobes of the enabled lanes then stay low for a set window. Finally RAS returns high for a precharge period before the next request can be accepted.

Writes always use early-write timing. WE is already low when the strobes fall, so the DRAM never drives its data pins during a write. The bidirectional data bus appears as separate input, output and drive-enable signals. The controller enables its own driver only while a write is in flight, and never while OE is low.

Top module: `edo_lane_ctrl`

## Requirements
- R1: While reset is asserted and afterwards until the first request, `dram_ras_n`, `dram_ucas_n`, `dram_lcas_n`, `dram_we_n` and `dram_oe_n` are high, and `dram_dq_oe` and `rsp_ack` are low.
- R2: The row part of the address, `req_addr[19:8]`, is on `dram_addr` when RAS falls. The column part, `req_addr[7:0]` zero-extended to 12 bits, is on `dram_addr` when the strobes fall. Words whose addresses differ only in the row bits are stored separately.
- R3: `req_be[0]` drives `dram_lcas_n` and covers data bits 7:0. `req_be[1]` drives `dram_ucas_n` and covers data bits 15:8. The strobe of a lane whose enable is 0 stays high for the whole access, so a write leaves that byte of memory unchanged.
- R4: When both lanes are enabled, both strobes fall on the same clock edge.
- R5: In a write (`req_wr`=1), `dram_we_n` is low at least one cycle before the strobes fall and stays low while they are low. `dram_oe_n` stays high, and `dram_dq_out` carries the write data while `dram_dq_oe` is high.
- R6: `dram_dq_oe` is high only during a write, and never while `dram_oe_n` is low.
- R7: In a read, `dram_oe_n` is low while the strobes are low. The data is sampled in the last cycle of the strobe window and returned on `rsp_rdata` with `rsp_ack`. Bits of lanes that are not enabled read as zero.
- R8: With the default parameters, RAS is low for 1 cycle before the column phase. The column address leads the strobes by 1 cycle, the strobes stay low for 3 cycles (`CAS_CYC`), and RAS stays high for at least 2 cycles (`PRE_CYC`) between accesses. `rsp_ack` is high during the 6th falling clock edge after `req` is raised in the idle state.
- R9: `req` is only accepted while the controller is idle. `rsp_ack` is a single-cycle pulse, and each accepted request produces exactly one RAS cycle even if `req` stays high a cycle past the ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until ack |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in bits 19:8, column in 7:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enable, bit 0 low lane, bit 1 high lane |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with ack |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_ucas_n | output | 1 | High-lane column strobe, active low |
| dram_lcas_n | output | 1 | Low-lane column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_in | input | 16 | Data from DRAM pins |
| dram_dq_out | output | 16 | Data toward DRAM pins |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |

## Verification
A memory model attached to the pins is driven with full-word writes and reads at addresses that differ only in the row bits. This shows whether the row and column halves are multiplexed correctly or alias. Single-lane writes over a known word, followed by full reads, show whether each enable reaches the right strobe and byte. A write with no lane enabled shows that nothing is changed. Single-lane reads show the zero-fill of the disabled lane. An access whose request is held past its ack shows whether a request can be accepted outside the idle state.

// File: rtl/edo_lane_pkg.sv
package edo_lane_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ROW  = 3'd1,
    ST_COL  = 3'd2,
    ST_STRB = 3'd3,
    ST_PRE  = 3'd4
  } edo_state_t;
endpackage

// File: rtl/edo_cycle_timer.sv
module edo_cycle_timer #(
  parameter int TW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = load_val;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_addr_mux.sv
module edo_addr_mux #(
  parameter int ROW_W = 12,
  parameter int COL_W = 8,
  parameter int PIN_W = 12
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic                   sel_col,
  output logic [PIN_W-1:0]       pins
);
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  assign row  = addr[ROW_W+COL_W-1:COL_W];
  assign col  = addr[COL_W-1:0];
  assign pins = sel_col ? PIN_W'(col) : PIN_W'(row);
endmodule

// File: rtl/edo_lane_map.sv
module edo_lane_map #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic [LANES-1:0]        be,
  input  logic                    strobe,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES-1:0]        cas_n,
  output logic [LANES*LANE_W-1:0] rd_masked
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_n[g] = ~(strobe & be[g]);
    assign rd_masked[g*LANE_W +: LANE_W] =
      be[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/edo_lane_ctrl.sv
module edo_lane_ctrl #(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 8,
  parameter int LANE_W  = 8,
  parameter int ROW_CYC = 1,
  parameter int CAS_CYC = 3,
  parameter int PRE_CYC = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req,
  input  logic                              req_wr,
  input  logic [ROW_W+COL_W-1:0]            req_addr,
  input  logic [2*LANE_W-1:0]               req_wdata,
  input  logic [1:0]                        req_be,
  output logic                              rsp_ack,
  output logic [2*LANE_W-1:0]               rsp_rdata,
  output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
  output logic                              dram_ras_n,
  output logic                              dram_ucas_n,
  output logic                              dram_lcas_n,
  output logic                              dram_we_n,
  output logic                              dram_oe_n,
  input  logic [2*LANE_W-1:0]               dram_dq_in,
  output logic [2*LANE_W-1:0]               dram_dq_out,
  output logic                              dram_dq_oe
);
  import edo_lane_pkg::*;

  localparam int LANES = 2;
  localparam int AW    = ROW_W + COL_W;
  localparam int DW    = LANES * LANE_W;
  localparam int PIN_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int MAXC  = (ROW_CYC > CAS_CYC) ?
                         ((ROW_CYC > PRE_CYC) ? ROW_CYC : PRE_CYC) :
                         ((CAS_CYC > PRE_CYC) ? CAS_CYC : PRE_CYC);
  localparam int TW    = (MAXC < 2) ? 1 : $clog2(MAXC);

  edo_state_t       state_q, state_d;
  logic             wr_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] be_q;
  logic             ack_q;
  logic [DW-1:0]    rdata_q;

  logic             accept;
  logic             capture;
  logic             t_load;
  logic [TW-1:0]    t_val;
  logic             t_done;

  logic             in_ras;
  logic             in_col;
  logic             in_strb;
  logic [LANES-1:0] cas_n;
  logic [DW-1:0]    rd_masked;

  // next-state logic
  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    capture = 1'b0;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        accept  = 1'b1;
        state_d = ST_ROW;
        t_load  = 1'b1;
        t_val   = TW'(ROW_CYC - 1);
      end
      ST_ROW:  if (t_done) state_d = ST_COL;
      ST_COL: begin
        state_d = ST_STRB;
        t_load  = 1'b1;
        t_val   = TW'(CAS_CYC - 1);
      end
      ST_STRB: if (t_done) begin
        capture = 1'b1;
        state_d = ST_PRE;
        t_load  = 1'b1;
        t_val   = TW'(PRE_CYC - 1);
      end
      ST_PRE:  if (t_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // request capture, enabled on accept
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      wr_q    <= req_wr;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= capture;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= wr_q ? '0 : rd_masked;
  end

  edo_cycle_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  assign in_col  = (state_q == ST_COL);
  assign in_strb = (state_q == ST_STRB);
  assign in_ras  = (state_q == ST_ROW) | in_col | in_strb;

  edo_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_amux (
    .addr    (addr_q),
    .sel_col (in_col | in_strb),
    .pins    (dram_addr)
  );

  edo_lane_map #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .be        (be_q),
    .strobe    (in_strb),
    .dq_in     (dram_dq_in),
    .cas_n     (cas_n),
    .rd_masked (rd_masked)
  );

  assign dram_ras_n  = ~in_ras;
  assign dram_lcas_n = cas_n[0];
  assign dram_ucas_n = cas_n[1];
  assign dram_we_n   = ~(wr_q & (in_col | in_strb));
  assign dram_dq_oe  = wr_q & (in_col | in_strb);
  assign dram_dq_out = wdata_q;
  assign dram_oe_n   = ~(~wr_q & in_strb);
  assign rsp_ack     = ack_q;
  assign rsp_rdata   = rdata_q;
endmodule

// File: rtl/edo_lane_chk.sv
module edo_lane_chk #(
  parameter int PRE_CYC = 2
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic ucas_n,
  input logic lcas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic ack
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       hi_cnt <= 16'(PRE_CYC);
    else if (!ras_n)                  hi_cnt <= '0;
    else if (hi_cnt < 16'(PRE_CYC))   hi_cnt <= hi_cnt + 1'b1;
  end

  a_r4_lanes_together: assert property (@(posedge clk) disable iff (!rst_n)
    (!ucas_n && !lcas_n) |-> ($fell(ucas_n) == $fell(lcas_n)));

  a_r5_we_leads_cas: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(lcas_n) || $fell(ucas_n)) && !we_n) |-> $past(!we_n));

  a_r5_write_no_oe: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  a_r5_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !we_n);

  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  a_r8_cas_in_ras: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcas_n || !ucas_n) |-> !ras_n);

  a_r8_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (hi_cnt >= 16'(PRE_CYC)));

  a_r9_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
endmodule

bind edo_lane_ctrl edo_lane_chk #(.PRE_CYC(PRE_CYC)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .ras_n  (dram_ras_n),
  .ucas_n (dram_ucas_n),
  .lcas_n (dram_lcas_n),
  .we_n   (dram_we_n),
  .oe_n   (dram_oe_n),
  .dq_oe  (dram_dq_oe),
  .ack    (rsp_ack)
);

// File: tb/edo_lane_ctrl_test.sv
`timescale 1ns/1ps
module edo_lane_ctrl_test;
  localparam int CAS_CYC = 3;
  localparam int PRE_CYC = 2;
  localparam int LAT     = 6;

  logic        clk;
  logic        rst_n;
  logic        req;
  logic        req_wr;
  logic [19:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_be;
  logic        rsp_ack;
  logic [15:0] rsp_rdata;
  logic [11:0] dram_addr;
  logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n;
  logic [15:0] dram_dq_in, dram_dq_out;
  logic        dram_dq_oe;

  edo_lane_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n),
    .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_in(dram_dq_in),
    .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- DRAM pin model ----------------
  logic [15:0] dmem [int unsigned];
  logic [11:0] row_l;
  logic [7:0]  col_l;
  logic [15:0] cell_q;
  logic        p_ras, p_l, p_u, p_we;
  int          ras_falls;
  int          cas_run;
  int          ras_hi_run;

  assign dram_dq_in[7:0]  = (!dram_lcas_n && !dram_oe_n) ? cell_q[7:0]  : 8'hA5;
  assign dram_dq_in[15:8] = (!dram_ucas_n && !dram_oe_n) ? cell_q[15:8] : 8'h5A;

  always @(negedge clk) begin
    if (!rst_n) begin
      p_ras = 1; p_l = 1; p_u = 1; p_we = 1;
      ras_falls = 0; cas_run = 0; ras_hi_run = 100;
      row_l = '0; col_l = '0; cell_q = '0;
    end else begin
      bit lf, uf;
      int unsigned key;
      lf = p_l && !dram_lcas_n;
      uf = p_u && !dram_ucas_n;
      if (p_ras && !dram_ras_n) begin
        ras_falls++;
        row_l = dram_addr;
        // R8: precharge before each new row cycle
        chk(ras_hi_run >= PRE_CYC, "R8 precharge", ras_hi_run, PRE_CYC);
      end
      if (lf || uf) begin
        col_l = dram_addr[7:0];
        chk(dram_addr[11:8] == 4'h0, "R2 col zero-extend", dram_addr, {4'h0, col_l});
        // R4: no strobe falls while the other lane is already low
        chk(!(lf && !uf && !dram_ucas_n) && !(uf && !lf && !dram_lcas_n),
            "R4 lanes together", {dram_ucas_n, dram_lcas_n}, 2'b00);
        key = {20'h0, row_l, col_l};
        if (!dram_we_n) begin
          chk(!p_we, "R5 WE before CAS", p_we, 0);
          chk(dram_oe_n && dram_dq_oe, "R5/R6 write drive", {dram_oe_n, dram_dq_oe}, 2'b11);
          if (!dmem.exists(key)) dmem[key] = '0;
          if (lf) dmem[key][7:0]  = dram_dq_out[7:0];
          if (uf) dmem[key][15:8] = dram_dq_out[15:8];
        end else begin
          chk(!dram_dq_oe, "R6 no drive in read", dram_dq_oe, 0);
        end
        cell_q = dmem.exists(key) ? dmem[key] : 16'h0;
      end
      if (!dram_lcas_n || !dram_ucas_n) cas_run++;
      else if (cas_run != 0) begin
        chk(cas_run == CAS_CYC, "R8 CAS width", cas_run, CAS_CYC);
        cas_run = 0;
      end
      if (dram_ras_n) ras_hi_run++;
      else            ras_hi_run = 0;
      p_ras = dram_ras_n; p_l = dram_lcas_n; p_u = dram_ucas_n; p_we = dram_we_n;
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct packed { logic rd; logic [15:0] exp; } item_t;
  item_t sbq[$];
  logic [15:0] shadow [int unsigned];

  always @(negedge clk) begin
    if (rst_n && rsp_ack) begin
      if (sbq.size() == 0) chk(0, "R9 unexpected ack", 1, 0);
      else begin
        item_t it;
        it = sbq.pop_front();
        if (it.rd) chk(rsp_rdata == it.exp, "R7 read data", rsp_rdata, it.exp);
      end
    end
  end

  task automatic access(input logic wr, input logic [19:0] a,
                        input logic [15:0] d, input logic [1:0] be,
                        input bit hold_extra);
    item_t it;
    logic [15:0] cur;
    int lat;
    int falls0;
    cur = shadow.exists(a) ? shadow[a] : 16'h0;
    if (wr) begin
      if (be[0]) cur[7:0]  = d[7:0];
      if (be[1]) cur[15:8] = d[15:8];
      shadow[a] = cur;
      it.exp = '0;
    end else begin
      it.exp = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
    end
    it.rd = !wr;
    sbq.push_back(it);
    @(negedge clk);
    falls0 = ras_falls;
    req = 1; req_wr = wr; req_addr = a; req_wdata = d; req_be = be;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rsp_ack && lat < 40);
    chk(lat == LAT, "R8 ack latency", lat, LAT);
    if (hold_extra) @(negedge clk);
    req = 0;
    chk(row_l == a[19:8], "R2 row address", row_l, a[19:8]);
    if (be != 2'b00) chk(col_l == a[7:0], "R2 column address", col_l, a[7:0]);
    repeat (PRE_CYC + 1 - (hold_extra ? 1 : 0)) @(negedge clk);
    chk(ras_falls - falls0 == 1, "R9 one RAS cycle", ras_falls - falls0, 1);
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 0; req = 0; req_wr = 0; req_addr = '0; req_wdata = '0; req_be = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe, rsp_ack}
        == 7'b1111100, "R1 reset pins",
        {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe, rsp_ack},
        7'b1111100);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe, rsp_ack}
        == 7'b1111100, "R1 idle pins",
        {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe, rsp_ack},
        7'b1111100);

    // R2: row aliasing
    access(1, 20'h12345, 16'hBEEF, 2'b11, 0);
    access(1, 20'h22345, 16'h1234, 2'b11, 0);
    access(0, 20'h12345, 16'h0,    2'b11, 0);
    access(0, 20'h22345, 16'h0,    2'b11, 0);
    // R3: single-lane writes
    access(1, 20'h12345, 16'hFF77, 2'b01, 0);
    access(0, 20'h12345, 16'h0,    2'b11, 0);
    access(1, 20'h12345, 16'h5566, 2'b10, 0);
    access(0, 20'h12345, 16'h0,    2'b11, 0);
    // R7: single-lane reads zero-fill
    access(0, 20'h12345, 16'h0,    2'b01, 0);
    access(0, 20'h12345, 16'h0,    2'b10, 0);
    // R3: write with no lane enabled changes nothing
    access(1, 20'h12345, 16'hFFFF, 2'b00, 0);
    access(0, 20'h12345, 16'h0,    2'b11, 0);
    // pattern sweep
    for (int i = 0; i < 6; i++)
      access(1, 20'(i * 32'h1_1111), 16'(16'hA0C3 ^ (i * 16'h1357)), 2'b11, 0);
    for (int i = 0; i < 6; i++)
      access(0, 20'(i * 32'h1_1111), 16'h0, 2'b11, 0);
    // R9: request held one cycle past ack
    access(0, 20'h22345, 16'h0, 2'b11, 1);
    access(1, 20'hFFFFF, 16'h0F0F, 2'b11, 1);
    access(0, 20'hFFFFF, 16'h0, 2'b11, 0);

    repeat (5) @(negedge clk);
    chk(sbq.size() == 0, "R9 all acks seen", sbq.size(), 0);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule